// File: doc/BRIEF.md
# Dual-Target Two-Wire Slave Front End

This block is the slave side of a two-wire serial bus (I2C / SMBus style) that serves two separate internal targets through one device address. One target is a small bank of temperature-sensor registers. The other is a byte-wide memory array, modelled here as an on-chip register array. The serial clock and data lines are oversampled in the system clock domain. START and STOP conditions are recognised there. The data line is driven back through a single pull-low enable, as an open-drain pad needs.

A transaction begins with an address byte. Its upper four bits choose the target. The next three bits must equal the board strap pins, and the last bit gives the direction. Each target keeps its own byte pointer. In a write, the first data byte sets that pointer and each later byte is stored at the pointer, which then steps forward. A read returns bytes from the current pointer of the chosen target, and the pointer steps forward for each byte. A repeated START lets a host set the pointer and read back in one transaction.

Top module: `i2c_dual_target`

## Requirements
- R1: The block ignores all bus activity until it sees a START, which is SDA falling while SCL is high. A START seen at any point, including in the middle of a transaction, restarts address decoding.
- R2: A STOP, which is SDA rising while SCL is high, ends the transaction, releases SDA and returns the block to idle.
- R3: The block treats any SDA change while SCL is high as a START or a STOP, never as a data bit. A STOP in the middle of an address byte therefore cancels it.
- R4: The address byte is received MSB first. Bits [7:4] = 4'b0011 select the sensor bank, bits [7:4] = 4'b1010 select the memory, bits [3:1] must equal `strap_addr[2:0]`, and bit [0] = 1 means read.
- R5: On a matching address the block acknowledges by holding SDA low from the SCL fall after the 8th bit until the SCL fall after the 9th clock.
- R6: An address with any other preamble, or with strap bits that do not match, gets no acknowledge. Neither target's pointer or contents change, and the block stays released until the next START.
- R7: In a write, every data byte received from the master is acknowledged in its 9th clock.
- R8: The first data byte of a write loads the selected target's pointer. The sensor bank uses the low 3 bits and the memory uses all 8 bits. Each later byte is stored at the pointer and the pointer then increments, wrapping at the end of the target's space.
- R9: In a read, bytes come from the selected target's pointer, MSB first, and the pointer increments once for each byte. SDA changes only after an SCL falling edge, never while SCL is high.
- R10: If the master does not acknowledge a read byte, the block releases SDA and sends nothing more until the next START.
- R11: The two targets keep separate pointers and separate storage, so a transaction on one target leaves the other target's pointer and contents unchanged.
- R12: After reset SDA is released, both pointers are zero and all stored bytes are zero.
- R13: `sda_drive_low` = 1 pulls the line low to send a 0. A 1 is sent by releasing the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock as seen on the bus |
| sda_in | input | 1 | Serial data as seen on the bus (wired-AND level) |
| strap_addr | input | 3 | Board strap bits compared with address bits [3:1] |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
On every cycle, the embedded assertions check the following:
- SDA drive changes only after an SCL fall, START or STOP.
- The block stays released while idle, and holds SDA low through each acknowledge slot.
- A START re-arms address decoding and a STOP forces idle.
- Each target sees at most one pointer operation per cycle, and its pointer either steps by exactly one or holds.

Some behaviour only the bench scenarios can show: which target is selected, preamble and strap mismatch handling, the pointer load and wrap, the separation between the two targets, the read data values, and the silence after a NoACK. The bench also compares the pull-low enable with its own model on every clock.

// File: rtl/i2c_dt_pkg.sv
// Package: shared state encoding, target selector and address preambles
// for the dual-target two-wire slave.
package i2c_dt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_AACK  = 3'd2,
        ST_WDATA = 3'd3,
        ST_WACK  = 3'd4,
        ST_RDATA = 3'd5,
        ST_RACK  = 3'd6
    } dt_state_t;

    localparam logic [3:0] PRE_SENSOR = 4'b0011;
    localparam logic [3:0] PRE_MEMORY = 4'b1010;

    localparam int TGT_SENSOR = 0;
    localparam int TGT_MEMORY = 1;
    localparam int NUM_TGT    = 2;

endpackage

// File: rtl/i2c_dt_sync.sv
// Module: i2c_dt_sync
// Brings SCL and SDA into the system clock domain through a flop chain.
// It then produces one-cycle pulses for the SCL edges and for START and STOP.
// Assumes the bus is idle-high and each SCL phase lasts several clk cycles.
module i2c_dt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] scl_pipe;
    logic [LAST:0] sda_pipe;
    logic          scl_q;
    logic          sda_q;
    logic          scl_s;
    logic          sda_s;

    generate
        if (STAGES == 1) begin : g_one
            // Purpose: single-stage capture of both lines
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_in;
                    sda_pipe <= sda_in;
                end
            end
        end else begin : g_chain
            // Purpose: multi-stage shift chain for metastability settling
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[LAST-1:0], scl_in};
                    sda_pipe <= {sda_pipe[LAST-1:0], sda_in};
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[LAST];
    assign sda_s = sda_pipe[LAST];

    // Purpose: one-cycle-old copies of the synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Purpose: derive edge and bus-condition pulses
    always_comb begin
        sda_lvl   = sda_s;
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_dt_bank.sv
// Module: i2c_dt_bank
// Byte storage with its own auto-incrementing pointer. It performs one of
// three operations per cycle: load the pointer, write at the pointer and
// advance, or advance after a read. rd_data always shows the byte at the
// pointer. Assumes DEPTH is a power of two and no larger than 2**DATA_W.
module i2c_dt_bank #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_load,
    input  logic              wr_en,
    input  logic              rd_adv,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rd_data
);
    localparam int               PTR_W   = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] PTR_ONE = 1;

    logic [PTR_W-1:0]  ptr;
    logic [DATA_W-1:0] store [DEPTH];

    // Purpose: pointer update and byte storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                store[i] <= '0;
            end
        end else if (ptr_load) begin
            ptr <= din[PTR_W-1:0];
        end else if (wr_en) begin
            store[ptr] <= din;
            ptr        <= ptr + PTR_ONE;
        end else if (rd_adv) begin
            ptr <= ptr + PTR_ONE;
        end
    end

    assign rd_data = store[ptr];

    AST_BANK_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ptr_load, wr_en, rd_adv})); // R8
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || rd_adv) |=> (ptr == $past(ptr) + PTR_ONE)); // R9
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(ptr_load || wr_en || rd_adv) |=> $stable(ptr)); // R11

endmodule

// File: rtl/i2c_dt_ctrl.sv
// Module: i2c_dt_ctrl
// Byte-level protocol engine. It shifts in the address and write bytes on
// SCL rises and decides ACK, target and direction. It drives read bytes and
// ACK slots after SCL falls, and issues pointer strobes to the selected
// target. Assumes event pulses come from i2c_dt_sync and that a START or
// STOP never coincides with an SCL edge.
module i2c_dt_ctrl
    import i2c_dt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sda_lvl,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 start_det,
    input  logic                 stop_det,
    input  logic [2:0]           strap_addr,
    input  logic [7:0]           rd_byte,
    output logic                 tgt,
    output logic [7:0]           rx_byte,
    output logic [NUM_TGT-1:0]   ptr_load,
    output logic [NUM_TGT-1:0]   wr_en,
    output logic [NUM_TGT-1:0]   rd_adv,
    output logic                 drive_low
);
    dt_state_t  state;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic [7:0] txreg;
    logic       is_read;
    logic       first_byte;
    logic       mack;
    logic       addr_ok;
    logic       commit;
    logic       load_tx;

    // Purpose: address match on preamble and strap bits
    always_comb begin
        addr_ok = (shreg[3:1] == strap_addr) &&
                  ((shreg[7:4] == PRE_SENSOR) || (shreg[7:4] == PRE_MEMORY));
    end

    // Purpose: byte-complete and byte-fetch events toward the targets
    always_comb begin
        commit  = (state == ST_WDATA) && scl_fall && (bitcnt == 4'd8);
        load_tx = scl_fall && (((state == ST_AACK) && is_read) ||
                               ((state == ST_RACK) && mack));
    end

    // Purpose: route strobes to the currently selected target only
    always_comb begin
        ptr_load = '0;
        wr_en    = '0;
        rd_adv   = '0;
        if (commit) begin
            if (first_byte) ptr_load[tgt] = 1'b1;
            else            wr_en[tgt]    = 1'b1;
        end
        if (load_tx) rd_adv[tgt] = 1'b1;
    end

    assign rx_byte = shreg;

    // Purpose: protocol state machine and SDA drive register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            txreg      <= '0;
            is_read    <= 1'b0;
            first_byte <= 1'b0;
            mack       <= 1'b0;
            tgt        <= 1'b0;
            drive_low  <= 1'b0;
        end else if (start_det) begin
            state     <= ST_ADDR;
            bitcnt    <= '0;
            drive_low <= 1'b0;
        end else if (stop_det) begin
            state     <= ST_IDLE;
            drive_low <= 1'b0;
        end else begin
            case (state)
                ST_ADDR: begin
                    if (scl_rise && bitcnt != 4'd8) begin
                        shreg  <= {shreg[6:0], sda_lvl};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall && bitcnt == 4'd8) begin
                        if (addr_ok) begin
                            drive_low  <= 1'b1;
                            tgt        <= (shreg[7:4] == PRE_MEMORY);
                            is_read    <= shreg[0];
                            first_byte <= 1'b1;
                            state      <= ST_AACK;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (is_read) begin
                            txreg     <= rd_byte;
                            drive_low <= ~rd_byte[7];
                            state     <= ST_RDATA;
                        end else begin
                            drive_low <= 1'b0;
                            state     <= ST_WDATA;
                        end
                    end
                end
                ST_WDATA: begin
                    if (scl_rise && bitcnt != 4'd8) begin
                        shreg  <= {shreg[6:0], sda_lvl};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall && bitcnt == 4'd8) begin
                        drive_low  <= 1'b1;
                        first_byte <= 1'b0;
                        state      <= ST_WACK;
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        drive_low <= 1'b0;
                        bitcnt    <= '0;
                        state     <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise && bitcnt != 4'd8) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            drive_low <= 1'b0;
                            state     <= ST_RACK;
                        end else begin
                            txreg     <= {txreg[6:0], 1'b0};
                            drive_low <= ~txreg[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_lvl;
                    end else if (scl_fall) begin
                        if (mack) begin
                            txreg     <= rd_byte;
                            drive_low <= ~rd_byte[7];
                            bitcnt    <= '0;
                            state     <= ST_RDATA;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !drive_low); // R6
    AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_low != $past(drive_low)) |->
        ($past(scl_fall) || $past(start_det) || $past(stop_det))); // R9
    AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && bitcnt == 4'd0 && !drive_low)); // R1
    AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !drive_low)); // R2
    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AACK || state == ST_WACK) |-> drive_low); // R5

endmodule

// File: rtl/i2c_dual_target.sv
// Module: i2c_dual_target (top)
// Two-wire slave front end that serves a sensor register bank and a memory
// array behind one strap-selected address. Assumes clk is several times
// faster than SCL, and that SDA is an external wired-AND with a pull-up.
module i2c_dual_target #(
    parameter int SENS_DEPTH  = 8,
    parameter int MEM_DEPTH   = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] strap_addr,
    output logic       sda_drive_low
);
    import i2c_dt_pkg::*;

    logic                 sda_lvl;
    logic                 scl_rise;
    logic                 scl_fall;
    logic                 start_det;
    logic                 stop_det;
    logic                 tgt;
    logic [7:0]           rx_byte;
    logic [7:0]           rd_byte;
    logic [NUM_TGT-1:0]   ptr_load;
    logic [NUM_TGT-1:0]   wr_en;
    logic [NUM_TGT-1:0]   rd_adv;
    logic [7:0]           rd_data [NUM_TGT];

    i2c_dt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_dt_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_lvl    (sda_lvl),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .strap_addr (strap_addr),
        .rd_byte    (rd_byte),
        .tgt        (tgt),
        .rx_byte    (rx_byte),
        .ptr_load   (ptr_load),
        .wr_en      (wr_en),
        .rd_adv     (rd_adv),
        .drive_low  (sda_drive_low)
    );

    generate
        for (genvar g = 0; g < NUM_TGT; g++) begin : g_bank
            localparam int DEPTH = (g == TGT_MEMORY) ? MEM_DEPTH : SENS_DEPTH;
            i2c_dt_bank #(.DEPTH(DEPTH), .DATA_W(8)) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .ptr_load (ptr_load[g]),
                .wr_en    (wr_en[g]),
                .rd_adv   (rd_adv[g]),
                .din      (rx_byte),
                .rd_data  (rd_data[g])
            );
        end
    endgenerate

    // Purpose: present the selected target's current byte to the engine
    always_comb begin
        rd_byte = tgt ? rd_data[TGT_MEMORY] : rd_data[TGT_SENSOR];
    end

endmodule

// File: tb/sim_i2c_dual_target.sv
module sim_i2c_dual_target;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 10;
    localparam int HOLD       = 5;
    localparam logic [3:0] P_SENS = 4'b0011;
    localparam logic [3:0] P_MEM  = 4'b1010;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] strap = 3'b010;
    logic       sda_drive_low;
    wire        sda_bus = m_sda & ~sda_drive_low;

    int   total = 0;
    int   bad = 0;
    logic exp_drive = 1'b0;
    int   fall_seq = 0;
    logic mon_en = 1'b0;
    string cur_req = "R12";

    logic [7:0] m_sens [8];
    logic [7:0] m_mem  [256];
    int sp = 0;
    int mp = 0;

    i2c_dual_target u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl),
        .sda_in        (sda_bus),
        .strap_addr    (strap),
        .sda_drive_low (sda_drive_low)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Per-clock comparison of the pull-low enable with the modelled value
    int mon_seen = 0;
    int mon_hold = 0;
    always @(negedge clk) begin
        if (mon_en) begin
            if (fall_seq != mon_seen) begin
                mon_seen = fall_seq;
                mon_hold = HOLD;
            end
            if (mon_hold > 0) mon_hold--;
            else begin
                total++;
                if (sda_drive_low !== exp_drive) begin
                    bad++;
                    $display("FAIL %s drive per-cycle: actual=%0b expected=%0b t=%0t",
                             cur_req, sda_drive_low, exp_drive, $time);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bit_cycle(input logic m, input logic e, output logic got);
        tick(2);
        m_sda = m;
        exp_drive = e;
        tick(HALF - 2);
        scl = 1'b1;
        tick(HALF/2);
        got = sda_bus;
        tick(HALF - HALF/2);
        scl = 1'b0;
        fall_seq++;
    endtask

    task automatic start_c();
        tick(2);
        m_sda = 1'b1;
        exp_drive = 1'b0;
        tick(HALF);
        scl = 1'b1;
        tick(HALF);
        m_sda = 1'b0;
        tick(HALF);
        scl = 1'b0;
        fall_seq++;
    endtask

    task automatic stop_c();
        tick(2);
        m_sda = 1'b0;
        exp_drive = 1'b0;
        tick(HALF);
        scl = 1'b1;
        tick(HALF);
        m_sda = 1'b1;
        tick(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
        logic g;
        cur_req = req;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], 1'b0, g);
        bit_cycle(1'b1, exp_ack, g);
        chk(g == ~exp_ack, {req, " ack slot"}, g, ~exp_ack);
    endtask

    task automatic recv_byte(input logic [7:0] e, input logic give_ack);
        logic g;
        logic [7:0] v;
        cur_req = "R9";
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, ~e[i], g);
            v[i] = g;
        end
        chk(v == e, "R9 R13 read byte", v, e);
        bit_cycle(~give_ack, 1'b0, g);
    endtask

    function automatic logic [7:0] adr(input logic [3:0] p, input logic [2:0] s, input logic rw);
        return {p, s, rw};
    endfunction

    function automatic logic [7:0] model_rd(input logic [3:0] p);
        logic [7:0] r;
        if (p == P_SENS) begin r = m_sens[sp]; sp = (sp + 1) % 8; end
        else begin r = m_mem[mp]; mp = (mp + 1) % 256; end
        return r;
    endfunction

    task automatic set_ptr(input logic [3:0] p, input logic [7:0] v);
        if (p == P_SENS) sp = v % 8; else mp = v;
    endtask

    task automatic do_write(input logic [3:0] p, input logic [7:0] ptr,
                            input logic [7:0] d [4], input int n);
        start_c();
        send_byte(adr(p, strap, 1'b0), 1'b1, "R5");
        send_byte(ptr, 1'b1, "R7");
        set_ptr(p, ptr);
        for (int k = 0; k < n; k++) begin
            send_byte(d[k], 1'b1, "R7 R8");
            if (p == P_SENS) begin m_sens[sp] = d[k]; sp = (sp + 1) % 8; end
            else begin m_mem[mp] = d[k]; mp = (mp + 1) % 256; end
        end
        stop_c();
    endtask

    task automatic read_tail(input logic [3:0] p, input int n);
        send_byte(adr(p, strap, 1'b1), 1'b1, "R5");
        for (int k = 0; k < n; k++) recv_byte(model_rd(p), k < n - 1);
        stop_c();
    endtask

    task automatic do_read(input logic [3:0] p, input int n);
        start_c();
        read_tail(p, n);
    endtask

    task automatic do_read_at(input logic [3:0] p, input logic [7:0] ptr, input int n);
        start_c();
        send_byte(adr(p, strap, 1'b0), 1'b1, "R5");
        send_byte(ptr, 1'b1, "R8");
        set_ptr(p, ptr);
        cur_req = "R1";
        start_c();
        read_tail(p, n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic g;
        for (int i = 0; i < 8; i++) m_sens[i] = 8'h00;
        for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
        tick(6);
        rst_n = 1'b1;
        tick(2);
        chk(sda_drive_low == 1'b0, "R12 reset release", sda_drive_low, 0);
        mon_en = 1'b1;

        // R1: bus traffic before any START draws no response
        cur_req = "R1";
        tick(2);
        scl = 1'b0;
        fall_seq++;
        for (int i = 7; i >= 0; i--) bit_cycle(adr(P_MEM, strap, 1'b0) >> i, 1'b0, g);
        bit_cycle(1'b1, 1'b0, g);
        chk(g == 1'b1, "R1 no ack before START", g, 1);
        stop_c();

        // R12: reset pointer zero and storage zero in sensor bank
        do_read(P_SENS, 1);

        // R8 write then R9 read with repeated START (R1)
        do_write(P_MEM, 8'h10, '{8'hA5, 8'h3C, 8'hFF, 8'h5A}, 4);
        do_read_at(P_MEM, 8'h10, 3);

        // R8: sensor pointer uses low 3 bits and wraps
        do_write(P_SENS, 8'h0E, '{8'h11, 8'h22, 8'h33, 8'h00}, 3);
        do_read_at(P_SENS, 8'h06, 3);

        // R11: memory pointer untouched by sensor traffic
        cur_req = "R11";
        do_read(P_MEM, 1);

        // R10: NoACK ends transmission
        start_c();
        send_byte(adr(P_MEM, strap, 1'b1), 1'b1, "R5");
        recv_byte(model_rd(P_MEM), 1'b0);
        cur_req = "R10";
        for (int i = 0; i < 9; i++) begin
            bit_cycle(1'b1, 1'b0, g);
            chk(g == 1'b1, "R10 released after NoACK", g, 1);
        end
        stop_c();

        // R6: strap mismatch, write attempt ignored
        start_c();
        send_byte(adr(P_MEM, strap ^ 3'b001, 1'b0), 1'b0, "R6");
        send_byte(8'h13, 1'b0, "R6");
        send_byte(8'h99, 1'b0, "R6");
        stop_c();
        // R6: unknown preamble
        start_c();
        send_byte(adr(4'b0101, strap, 1'b1), 1'b0, "R6");
        stop_c();
        // R6: sensor preamble with wrong strap
        start_c();
        send_byte(adr(P_SENS, strap ^ 3'b100, 1'b0), 1'b0, "R6");
        stop_c();
        do_read_at(P_MEM, 8'h13, 1);

        // R3: STOP inside an address byte cancels it
        start_c();
        cur_req = "R3";
        for (int i = 7; i >= 5; i--) bit_cycle(adr(P_MEM, strap, 1'b0) >> i, 1'b0, g);
        stop_c();
        scl = 1'b0;
        fall_seq++;
        for (int i = 4; i >= 0; i--) bit_cycle(adr(P_MEM, strap, 1'b0) >> i, 1'b0, g);
        bit_cycle(1'b1, 1'b0, g);
        chk(g == 1'b1, "R3 no ack after cancelling STOP", g, 1);
        stop_c();

        // R4: new strap value; R8: memory pointer wraps at 0xFF
        strap = 3'b101;
        do_write(P_MEM, 8'hFF, '{8'h77, 8'h88, 8'h00, 8'h00}, 2);
        do_read_at(P_MEM, 8'hFF, 2);

        // R4: old strap no longer answers
        start_c();
        send_byte(adr(P_MEM, 3'b010, 1'b1), 1'b0, "R4");
        stop_c();

        // R2: released and idle after STOP
        tick(HALF);
        chk(sda_drive_low == 1'b0, "R2 idle after STOP", sda_drive_low, 0);

        mon_en = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule